// File: doc/BRIEF.md
# Prescaled Wakeup Timer

This block is a slow, always-on timer that wakes the system after a programmed delay. A prescale divider turns the slow clock into count ticks: a divide value of N gives one tick every N+1 clock cycles. On each tick a 32-bit counter steps up by one. When the stepped value is equal to or greater than a programmed threshold, the block raises two sticky level outputs. One is a wakeup request to the power controller and the other is an interrupt to the processor.

Software drives the timer through a small register port. Each write takes one cycle and reads are combinational. Software can set the enable, the divide value and the threshold, and can write the count directly. It clears the two sticky flags by separate means. The wakeup flag is a plain stored bit, so writing 0 clears it. The interrupt status bit is cleared by writing 1 to it. If the timer is still enabled and the count is still at or above the threshold, the next tick raises both flags again.

Top module: `wake_tmr`

## Requirements
- R1: The register map uses these addresses. 0 is the control register, where bit 0 is the enable. 1 holds the 12-bit divide value in bits 11:0. 2 is the 32-bit count. 3 is the 32-bit threshold. 4 is the wakeup cause flag in bit 0. 5 is the interrupt status in bit 0. Each register reads back what is stored. Unused bits and unused addresses read 0.
- R2: After reset every register reads 0, and both the wakeup request and the interrupt are low.
- R3: While the timer is enabled, the count grows by exactly one once every N+1 cycles, where N is the divide value. The first step lands N+1 clock edges after the edge that wrote the enable.
- R4: An expiry happens on any tick where the stepped count is equal to or greater than the threshold. This includes a count that was written above the threshold. An expiry sets both the wakeup flag and the interrupt flag on the same edge as the count step.
- R5: The wakeup request stays high until software writes 0 to the cause register. Writing 1 to that register sets the request.
- R6: The interrupt stays high until software writes 1 to bit 0 of the status register. Writing 0 there has no effect.
- R7: After a clear, both flags rise again on the next tick if the timer is enabled and the count is still at or above the threshold. If an expiry and a clear land on the same edge, the expiry wins.
- R8: A write to the count takes priority over a tick on the same edge. The written value is stored exactly, and that tick does not cause an expiry.
- R9: Clearing the enable freezes the count and blocks new expiries. Flags that are already set stay set.
- R10: Disabling the timer returns the prescale phase to zero. After a re-enable, the first step comes a full N+1 edges after the enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow always-on clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Combinational read data |
| wake_req_o | output | 1 | Sticky wakeup request to the power controller |
| irq_o | output | 1 | Sticky interrupt to the processor |

## Verification
A wrong prescale phase shows up as a count step at the wrong edge. It is visible on the count read within one divide period of the enable write. A wrong compare or a missing sticky hold shows on wake_req_o and irq_o on the very edge where the threshold is reached, or on the edge after a clear write. A clear that is handled wrongly gives a flag that falls when it should not, or that fails to rise again on the next tick. That next tick is at most N+1 cycles later.

// File: rtl/wake_tmr_pkg.sv
`timescale 1ns/1ps
// Shared register addresses for the wakeup timer.
package wake_tmr_pkg;
    localparam int unsigned WT_ADDR_W = 3;

    typedef enum logic [WT_ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_PRESC  = 3'd1,
        REG_COUNT  = 3'd2,
        REG_THRESH = 3'd3,
        REG_CAUSE  = 3'd4,
        REG_STAT   = 3'd5
    } wt_reg_e;
endpackage

// File: rtl/wake_tmr_presc.sv
`timescale 1ns/1ps
// Prescale divider: emits one tick every DIV+1 enabled cycles.
// Assumes div_i may change at any time; a phase at or past it wraps at once.
// Phase returns to zero whenever the timer is disabled.
module wake_tmr_presc #(
    parameter int unsigned PRE_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] phase_q;
    logic             wrap;

    assign wrap   = (phase_q >= div_i);
    assign tick_o = en_i && wrap;

    // Advance the phase, wrap at the divide value, clear when disabled.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i) begin
            phase_q <= '0;
        end else if (wrap) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/wake_tmr_cnt.sv
`timescale 1ns/1ps
// Count register with direct load and threshold compare.
// A load beats a tick in the same cycle. hit_o flags a tick whose stepped
// value is at or above the threshold; the compare is one bit wider so a
// wrap past the top also counts as reaching it.
module wake_tmr_cnt #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W:0]   stepped;

    assign stepped = {1'b0, count_q} + 1'b1;
    assign hit_o   = tick_i && !ld_i && (stepped >= {1'b0, thresh_i});
    assign count_o = count_q;

    // Load from software first, otherwise step on each tick.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else if (ld_i) begin
            count_q <= ld_val_i;
        end else if (tick_i) begin
            count_q <= stepped[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/wake_tmr_flags.sv
`timescale 1ns/1ps
// Sticky wakeup and interrupt flags.
// The wakeup flag is a plain stored bit; the interrupt is cleared by a write of 1.
// A new expiry in the same cycle as a clear leaves the flag set.
module wake_tmr_flags (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    input  logic cause_we_i,
    input  logic cause_wd_i,
    input  logic stat_clr_i,
    output logic wake_o,
    output logic irq_o
);
    logic wake_q;
    logic irq_q;

    // Wakeup flag: set by expiry, otherwise follows software writes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wake_q <= 1'b0;
        end else if (fire_i) begin
            wake_q <= 1'b1;
        end else if (cause_we_i) begin
            wake_q <= cause_wd_i;
        end
    end

    // Interrupt flag: set by expiry, cleared by a write-one.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            irq_q <= 1'b0;
        end else if (fire_i) begin
            irq_q <= 1'b1;
        end else if (stat_clr_i) begin
            irq_q <= 1'b0;
        end
    end

    assign wake_o = wake_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/wake_tmr.sv
`timescale 1ns/1ps
// Prescaled wakeup timer top: register file, divider, counter and sticky flags.
// Assumes at most one register write per cycle. Reads are combinational.
module wake_tmr
    import wake_tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned PRE_W = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [WT_ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]     wr_data_i,
    input  logic [WT_ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]     rd_data_o,
    output logic                 wake_req_o,
    output logic                 irq_o
);
    localparam int unsigned PAD_W = CNT_W - PRE_W;

    logic             en_q;
    logic [PRE_W-1:0] presc_q;
    logic [CNT_W-1:0] thresh_q;
    logic [CNT_W-1:0] cnt_val;
    logic             tick;
    logic             fire;
    logic             we_ctrl, we_presc, we_count, we_thresh, we_cause, we_stat;

    assign we_ctrl   = wr_en_i && (wr_addr_i == REG_CTRL);
    assign we_presc  = wr_en_i && (wr_addr_i == REG_PRESC);
    assign we_count  = wr_en_i && (wr_addr_i == REG_COUNT);
    assign we_thresh = wr_en_i && (wr_addr_i == REG_THRESH);
    assign we_cause  = wr_en_i && (wr_addr_i == REG_CAUSE);
    assign we_stat   = wr_en_i && (wr_addr_i == REG_STAT);

    // Configuration registers written by software.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q     <= 1'b0;
            presc_q  <= '0;
            thresh_q <= '0;
        end else begin
            if (we_ctrl)   en_q     <= wr_data_i[0];
            if (we_presc)  presc_q  <= wr_data_i[PRE_W-1:0];
            if (we_thresh) thresh_q <= wr_data_i;
        end
    end

    wake_tmr_presc #(.PRE_W(PRE_W)) presc_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_q),
        .div_i  (presc_q),
        .tick_o (tick)
    );

    wake_tmr_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .ld_i     (we_count),
        .ld_val_i (wr_data_i),
        .thresh_i (thresh_q),
        .count_o  (cnt_val),
        .hit_o    (fire)
    );

    wake_tmr_flags flags_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fire_i     (fire),
        .cause_we_i (we_cause),
        .cause_wd_i (wr_data_i[0]),
        .stat_clr_i (we_stat && wr_data_i[0]),
        .wake_o     (wake_req_o),
        .irq_o      (irq_o)
    );

    // Read multiplexer; unused bits and addresses return zero.
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            REG_CTRL:   rd_data_o[0] = en_q;
            REG_PRESC:  rd_data_o = {{PAD_W{1'b0}}, presc_q};
            REG_COUNT:  rd_data_o = cnt_val;
            REG_THRESH: rd_data_o = thresh_q;
            REG_CAUSE:  rd_data_o[0] = wake_req_o;
            REG_STAT:   rd_data_o[0] = irq_o;
            default:    rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/wake_tmr_chk.sv
`timescale 1ns/1ps
// Property checker for the wakeup timer, attached through bind.
// Observes ports plus the enable and count held inside the top.
module wake_tmr_chk
    import wake_tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 wr_en_i,
    input logic [WT_ADDR_W-1:0] wr_addr_i,
    input logic [CNT_W-1:0]     wr_data_i,
    input logic                 wake_req_o,
    input logic                 irq_o,
    input logic                 en_q,
    input logic [CNT_W-1:0]     cnt_val
);
    logic cnt_wr;
    assign cnt_wr = wr_en_i && (wr_addr_i == REG_COUNT);

    AST_WAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_req_o && !(wr_en_i && wr_addr_i == REG_CAUSE)) |=> wake_req_o); // R5
    AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !(wr_en_i && wr_addr_i == REG_STAT && wr_data_i[0])) |=> irq_o); // R6
    AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_q && !cnt_wr) |=> $stable(cnt_val)); // R9
    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_q && !cnt_wr) |=> (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) + 1'b1)); // R3
    AST_RISE_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(en_q)); // R9
    AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr |=> (cnt_val == $past(wr_data_i))); // R8
endmodule

bind wake_tmr wake_tmr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .wake_req_o (wake_req_o),
    .irq_o      (irq_o),
    .en_q       (en_q),
    .cnt_val    (cnt_val)
);

// File: tb/wake_tmr_tb_top.sv
`timescale 1ns/1ps
// Bench for the wakeup timer: a vector table walked by one loop, then directed cases.
module wake_tmr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wake, irq;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    localparam logic [2:0] A_CTRL = 3'd0, A_PRESC = 3'd1, A_COUNT = 3'd2;
    localparam logic [2:0] A_THR = 3'd3, A_CAUSE = 3'd4, A_STAT = 3'd5;

    // Each row: divide value, threshold, edges waited after the enable write.
    localparam int unsigned NV = 8;
    localparam int unsigned VEC [NV][3] = '{
        '{0, 5, 4}, '{0, 5, 5}, '{3, 2, 7}, '{3, 2, 8},
        '{2, 0, 2}, '{2, 0, 3}, '{11, 1, 30}, '{0, 10, 9}
    };

    always #5 clk = ~clk;

    wake_tmr dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .wake_req_o (wake),
        .irq_o      (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; one write consumes exactly one rising edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic clear_all();
        wr(A_CTRL, 0); wr(A_COUNT, 0); wr(A_CAUSE, 0); wr(A_STAT, 1);
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #100us;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state of every register and both outputs.
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R2 reset reg", d, 0);
        end
        chk("R2 reset wake", {31'd0, wake}, 0);
        chk("R2 reset irq", {31'd0, irq}, 0);

        // R1: readback, field truncation, unused address.
        wr(A_PRESC, 32'hFFFF_FABC);
        rd(A_PRESC, d); chk("R1 presc width", d, 32'h0000_0ABC);
        wr(A_THR, 32'h1234_5678);
        rd(A_THR, d); chk("R1 thresh", d, 32'h1234_5678);
        wr(A_COUNT, 32'hDEAD_BEEF);
        rd(A_COUNT, d); chk("R1 count", d, 32'hDEAD_BEEF);
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd(A_CTRL, d); chk("R1 ctrl bit0 only", d, 0);
        rd(3'd6, d); chk("R1 unused addr", d, 0);

        // R3 and R4: vector table over divide values and thresholds.
        for (int v = 0; v < NV; v++) begin
            int unsigned ec;
            logic ef;
            clear_all();
            wr(A_PRESC, VEC[v][0]);
            wr(A_THR, VEC[v][1]);
            wr(A_CTRL, 1);
            wait_edges(int'(VEC[v][2]));
            ec = VEC[v][2] / (VEC[v][0] + 1);
            ef = (ec >= 1) && (ec >= VEC[v][1]);
            rd(A_COUNT, d); chk("R3 count rate", d, ec);
            chk("R4 wake on reach", {31'd0, wake}, {31'd0, ef});
            chk("R4 irq on reach", {31'd0, irq}, {31'd0, ef});
        end

        // R4: count written above the threshold fires on the first tick.
        clear_all();
        wr(A_PRESC, 0); wr(A_THR, 32'hFFFF_FFF5); wr(A_COUNT, 32'hFFFF_FFF8);
        wr(A_CTRL, 1);
        wait_edges(1);
        rd(A_COUNT, d); chk("R4 past count", d, 32'hFFFF_FFF9);
        chk("R4 past wake", {31'd0, wake}, 1);
        chk("R4 past irq", {31'd0, irq}, 1);

        // R5, R6, R7: clears and re-fire with divide 20, threshold 1.
        clear_all();
        wr(A_PRESC, 20); wr(A_THR, 1);
        wr(A_CTRL, 1);
        wait_edges(21);
        chk("R4 first expiry", {31'd0, wake, irq}, 3);
        wr(A_CAUSE, 0);
        chk("R5 wake cleared", {31'd0, wake}, 0);
        chk("R5 irq untouched", {31'd0, irq}, 1);
        wr(A_STAT, 0);
        chk("R6 write0 no effect", {31'd0, irq}, 1);
        wr(A_STAT, 1);
        chk("R6 irq cleared", {31'd0, irq}, 0);
        wait_edges(17);
        chk("R7 quiet before tick", {31'd0, wake, irq}, 0);
        wait_edges(1);
        chk("R7 refire", {31'd0, wake, irq}, 3);
        rd(A_COUNT, d); chk("R7 count", d, 2);

        // R9: disable freezes count and keeps flags; no new expiries.
        wr(A_CTRL, 0);
        wait_edges(50);
        rd(A_COUNT, d); chk("R9 frozen count", d, 2);
        chk("R9 flags kept", {31'd0, wake, irq}, 3);
        wr(A_CAUSE, 0); wr(A_STAT, 1);
        wait_edges(30);
        chk("R9 no new expiry", {31'd0, wake, irq}, 0);

        // R5: software can set the wakeup flag.
        wr(A_CAUSE, 1);
        chk("R5 software set", {31'd0, wake}, 1);
        wr(A_CAUSE, 0);

        // R8: count write beats a same-edge tick.
        clear_all();
        wr(A_PRESC, 0); wr(A_THR, 32'hFFFF_FFFF);
        wr(A_CTRL, 1);
        wait_edges(3);
        wr(A_COUNT, 100);
        rd(A_COUNT, d); chk("R8 load wins", d, 100);
        wait_edges(1);
        rd(A_COUNT, d); chk("R8 step after load", d, 101);

        // R10: prescale phase restarts after a disable.
        clear_all();
        wr(A_PRESC, 5); wr(A_THR, 32'hFFFF_FFFF);
        wr(A_CTRL, 1);
        wait_edges(3);
        wr(A_CTRL, 0);
        wr(A_CTRL, 1);
        wait_edges(5);
        rd(A_COUNT, d); chk("R10 no early step", d, 0);
        wait_edges(1);
        rd(A_COUNT, d); chk("R10 full period", d, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule